// File: doc/BRIEF.md
# Expandable Five-Bit Magnitude Comparator

This block compares two unsigned words, `a` and `b`, each five bits wide by default, and raises exactly one of three flags: `gt`, `lt` or `eq`. It has no clock and no registers. Every output follows the inputs through logic alone.

Two serial cascade inputs, `cas_a` and `cas_b`, act as one extra bit pair below the words. The result is therefore the comparison of `{a, cas_a}` against `{b, cas_b}`. Wider words are compared with a chain of stages:

- Each stage takes the next more significant slice of the words.
- A stage's `gt` output feeds `cas_a` of the stage above it.
- A stage's `lt` output feeds `cas_b` of the stage above it.
- The least significant stage ties both cascade inputs low.
- The most significant stage delivers the final answer.

The enable `en_n` is active low. While it is high, all three flags are held low.

There is no data stream here, so no handshake is used. Every pin is a plain level.

Top module: `cascade_mag_cmp`

## Requirements
- R1: With `en_n` low and `a` greater than `b` as unsigned numbers, `gt` is 1 and `lt`, `eq` are 0, whatever the cascade inputs are.
- R2: With `en_n` low and `a` less than `b`, `lt` is 1 and `gt`, `eq` are 0, whatever the cascade inputs are.
- R3: With `en_n` low, `a` equal to `b`, and `cas_a` = `cas_b` = 0, `eq` is 1 and the other two flags are 0.
- R4: With `en_n` low and `a` equal to `b`, `cas_a`=1 with `cas_b`=0 gives `gt`=1, and `cas_a`=0 with `cas_b`=1 gives `lt`=1. In both cases the other flags are 0.
- R5: With `en_n` low, `a` equal to `b`, and both cascade inputs 1, the cascade pair counts as equal and `eq` is 1.
- R6: While `en_n` is low, exactly one of `gt`, `lt`, `eq` is 1.
- R7: While `en_n` is 1, `gt`, `lt` and `eq` are all 0.
- R8: A chain of stages, linked `gt`→`cas_a` and `lt`→`cas_b` from less to more significant, gives at its top stage the unsigned comparison of the concatenated wide words.
- R9: Outputs depend only on the present inputs, with no clock and no stored state. A new input is reflected in the same cycle it is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH (5) | Word A, unsigned |
| b | input | WIDTH (5) | Word B, unsigned |
| en_n | input | 1 | Active-low enable; high forces all flags low |
| cas_a | input | 1 | Cascade bit on the A side, from a lower stage's `gt` |
| cas_b | input | 1 | Cascade bit on the B side, from a lower stage's `lt` |
| gt | output | 1 | A side greater |
| lt | output | 1 | A side less |
| eq | output | 1 | Both sides equal |

## Verification
A single stage is driven through every combination of both words, both cascade bits and the enable. This covers unequal words, which must override the cascade, and equal words, where the cascade alone decides. It also separates the mixed cascade pairs, which pick `gt` or `lt`, from the matched pairs, which leave `eq`. The disabled half of the sweep shows that the enable masks every flag, whatever the comparison would have been.

A three-stage chain then receives random 15-bit pairs, plus pairs that differ only in the lowest or only in the highest slice. These show that a difference propagates from the bottom stage through equal upper stages, and that a higher slice overrides a lower one.

// File: rtl/cascade_mag_cmp_pkg.sv
package cascade_mag_cmp_pkg;
  typedef enum logic [1:0] {
    CMP_EQ = 2'b00,
    CMP_LT = 2'b01,
    CMP_GT = 2'b10
  } cmp_res_e;
endpackage

// File: rtl/cmp_bit_slice.sv
module cmp_bit_slice (
  input  logic a_bit,
  input  logic b_bit,
  output logic bit_gt,
  output logic bit_lt
);
  assign bit_gt = a_bit & ~b_bit;
  assign bit_lt = ~a_bit & b_bit;
endmodule

// File: rtl/cmp_priority_merge.sv
module cmp_priority_merge
  import cascade_mag_cmp_pkg::*;
#(
  parameter int N = 6
) (
  input  logic [N-1:0] bit_gt,
  input  logic [N-1:0] bit_lt,
  output cmp_res_e     result
);
  // the most significant differing bit position decides
  always_comb begin
    result = CMP_EQ;
    for (int i = 0; i < N; i++) begin
      if (bit_gt[i]) result = CMP_GT;
      else if (bit_lt[i]) result = CMP_LT;
    end
  end
endmodule

// File: rtl/cmp_enable_gate.sv
module cmp_enable_gate
  import cascade_mag_cmp_pkg::*;
(
  input  cmp_res_e result,
  input  logic     en_n,
  output logic     gt,
  output logic     lt,
  output logic     eq
);
  always_comb begin
    gt = 1'b0;
    lt = 1'b0;
    eq = 1'b0;
    if (!en_n) begin
      unique case (result)
        CMP_GT:  gt = 1'b1;
        CMP_LT:  lt = 1'b1;
        default: eq = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/cascade_mag_cmp.sv
module cascade_mag_cmp
  import cascade_mag_cmp_pkg::*;
#(
  parameter int WIDTH = 5
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             en_n,
  input  logic             cas_a,
  input  logic             cas_b,
  output logic             gt,
  output logic             lt,
  output logic             eq
);
  localparam int EXT_W = WIDTH + 1;

  logic [EXT_W-1:0] ext_a;
  logic [EXT_W-1:0] ext_b;
  logic [EXT_W-1:0] slice_gt;
  logic [EXT_W-1:0] slice_lt;
  cmp_res_e         merged;

  // cascade pair sits below the words as bit 0
  assign ext_a = {a, cas_a};
  assign ext_b = {b, cas_b};

  for (genvar gi = 0; gi < EXT_W; gi++) begin : g_slice
    cmp_bit_slice u_slice (
      .a_bit  (ext_a[gi]),
      .b_bit  (ext_b[gi]),
      .bit_gt (slice_gt[gi]),
      .bit_lt (slice_lt[gi])
    );
  end

  cmp_priority_merge #(.N(EXT_W)) u_merge (
    .bit_gt (slice_gt),
    .bit_lt (slice_lt),
    .result (merged)
  );

  cmp_enable_gate u_gate (
    .result (merged),
    .en_n   (en_n),
    .gt     (gt),
    .lt     (lt),
    .eq     (eq)
  );
endmodule

// File: rtl/cascade_mag_cmp_chk.sv
module cascade_mag_cmp_chk #(
  parameter int WIDTH = 5
) (
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic             en_n,
  input logic             cas_a,
  input logic             cas_b,
  input logic             gt,
  input logic             lt,
  input logic             eq
);
  logic known;
  assign known = !$isunknown({a, b, en_n, cas_a, cas_b, gt, lt, eq});

  always_comb begin
    if (known) begin
      // R6
      one_flag_chk: assert (en_n || $countones({gt, lt, eq}) == 1);
      // R7
      masked_low_chk: assert (!en_n || {gt, lt, eq} == 3'b000);
      // R1
      word_gt_chk: assert (en_n || !(a > b) || gt);
      // R2
      word_lt_chk: assert (en_n || !(a < b) || lt);
      // R3
      plain_eq_chk: assert (en_n || a != b || cas_a || cas_b || eq);
      // R4
      cas_up_chk: assert (en_n || a != b || !(cas_a && !cas_b) || gt);
      // R4
      cas_down_chk: assert (en_n || a != b || !(!cas_a && cas_b) || lt);
      // R5
      cas_tie_chk: assert (en_n || a != b || !(cas_a && cas_b) || eq);
    end
  end
endmodule

bind cascade_mag_cmp cascade_mag_cmp_chk #(.WIDTH(WIDTH)) u_chk (
  .a(a), .b(b), .en_n(en_n), .cas_a(cas_a), .cas_b(cas_b),
  .gt(gt), .lt(lt), .eq(eq)
);

// File: tb/cascade_mag_cmp_bench.sv
`timescale 1ns/1ps
module cascade_mag_cmp_bench;
  localparam int W      = 5;
  localparam int STAGES = 3;
  localparam int WIDE   = W * STAGES;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // single stage under test
  logic [W-1:0] a, b;
  logic en_n, cas_a, cas_b;
  logic gt, lt, eq;

  cascade_mag_cmp #(.WIDTH(W)) u_cascade_mag_cmp (
    .a(a), .b(b), .en_n(en_n), .cas_a(cas_a), .cas_b(cas_b),
    .gt(gt), .lt(lt), .eq(eq)
  );

  // chain of stages, R8
  logic [WIDE-1:0]   wa, wb;
  logic              chain_en_n;
  logic [STAGES-1:0] c_gt, c_lt, c_eq;

  for (genvar s = 0; s < STAGES; s++) begin : g_chain
    logic ca, cb;
    if (s == 0) begin : g_first
      assign ca = 1'b0;
      assign cb = 1'b0;
    end else begin : g_next
      assign ca = c_gt[s-1];
      assign cb = c_lt[s-1];
    end
    cascade_mag_cmp #(.WIDTH(W)) u_stage (
      .a(wa[s*W +: W]), .b(wb[s*W +: W]),
      .en_n((s == STAGES-1) ? chain_en_n : 1'b0),
      .cas_a(ca), .cas_b(cb),
      .gt(c_gt[s]), .lt(c_lt[s]), .eq(c_eq[s])
    );
  end

  task automatic check(input string tag, input logic [2:0] got, input logic [2:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got {gt,lt,eq}=%b expected %b (a=%0d b=%0d en_n=%b cas=%b%b)",
               tag, got, exp, a, b, en_n, cas_a, cas_b);
    end
  endtask

  // behavioural reference: integer compare of the extended words
  function automatic logic [2:0] ref_one(int ia, int ib, bit e_n, bit ca, bit cb);
    int xa = ia * 2 + ca;
    int xb = ib * 2 + cb;
    if (e_n) return 3'b000;
    if (xa > xb) return 3'b100;
    if (xa < xb) return 3'b010;
    return 3'b001;
  endfunction

  function automatic string tag_of(int ia, int ib, bit e_n, bit ca, bit cb);
    if (e_n) return "R7";
    if (ia > ib) return "R1";
    if (ia < ib) return "R2";
    if (!ca && !cb) return "R3";
    if (ca && cb) return "R5";
    return "R4";
  endfunction

  task automatic run_chain(input logic [WIDE-1:0] xa, input logic [WIDE-1:0] xb, input bit e_n);
    logic [2:0] exp;
    @(negedge clk);
    wa = xa; wb = xb; chain_en_n = e_n;
    #1;
    if (e_n) exp = 3'b000;
    else if (xa > xb) exp = 3'b100;
    else if (xa < xb) exp = 3'b010;
    else exp = 3'b001;
    total++;
    if ({c_gt[STAGES-1], c_lt[STAGES-1], c_eq[STAGES-1]} !== exp) begin
      bad++;
      $display("FAIL R8: chain got %b expected %b (a=%h b=%h)",
               {c_gt[STAGES-1], c_lt[STAGES-1], c_eq[STAGES-1]}, exp, xa, xb);
    end
  endtask

  initial begin
    a = '0; b = '0; en_n = 1'b1; cas_a = 1'b0; cas_b = 1'b0;
    wa = '0; wb = '0; chain_en_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R7 reset", {gt, lt, eq}, 3'b000);
    rst_n = 1'b1;

    // exhaustive single-stage sweep, R1..R7
    for (int e = 0; e < 2; e++)
      for (int ia = 0; ia < (1 << W); ia++)
        for (int ib = 0; ib < (1 << W); ib++)
          for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            a = W'(ia); b = W'(ib); en_n = e[0];
            cas_a = c[1]; cas_b = c[0];
            #1;
            check(tag_of(ia, ib, e[0], c[1], c[0]), {gt, lt, eq},
                  ref_one(ia, ib, e[0], c[1], c[0]));
          end

    // R9: same-cycle response to a change with no clock edge between
    @(negedge clk);
    a = 5'd7; b = 5'd7; en_n = 1'b0; cas_a = 1'b0; cas_b = 1'b0;
    #1 check("R9", {gt, lt, eq}, 3'b001);
    a = 5'd8;
    #1 check("R9", {gt, lt, eq}, 3'b100);

    // chain directed corners, R8
    run_chain(15'd1, 15'd0, 1'b0);
    run_chain(15'd0, 15'd1, 1'b0);
    run_chain(15'h4000, 15'h3fff, 1'b0);
    run_chain(15'h3fff, 15'h4000, 1'b0);
    run_chain(15'h1234, 15'h1234, 1'b0);
    run_chain(15'h7fff, 15'h0000, 1'b1);
    // chain random vectors, R8
    for (int k = 0; k < 600; k++) begin
      logic [WIDE-1:0] ra, rb;
      ra = WIDE'($urandom);
      rb = (k % 4 == 0) ? ra ^ WIDE'(1 << ($urandom % WIDE)) : WIDE'($urandom);
      run_chain(ra, rb, 1'b0);
    end

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule